// File: doc/BRIEF.md
# Hardwired Instruction Sequencer with Interrupt Cycle

This block is the timing and control unit of a 16-bit accumulator machine with a 12-bit address space. A sequence counter is decoded into one-hot timing phases, and the three opcode bits of the instruction register are decoded into eight one-hot operation lines. From these the block steps each instruction through fetch, decode and an optional indirect-address read. It then runs one of three execution paths: memory-reference, register-reference or input/output. It owns the program counter, address register, instruction register, data and temporary registers, the indirect bit, the interrupt-pending and interrupt-enable flip-flops, the run/halt flip-flop and the memory strobes.

The memory sits outside and answers within the same clock, so read data is used in the phase that asserts the read strobe and a write is committed at the end of the phase that asserts the write strobe. The accumulator datapath is also outside. It supplies the accumulator value and carry bit for stores and skip tests, and it reads the phase, operation and instruction outputs to perform its own transfers. When interrupts are enabled and a device flag is up, the next instruction cycle is replaced by a three-phase hardware call. This call saves the return address at address 0 and continues at address 1.

Top module: `instr_sequencer`

## Requirements
- R1: Synchronous reset leaves phase T0 active (`t_phase` = 1), PC = 0, interrupt-pending and interrupt-enable cleared, and the run flip-flop set.
- R2: With no interrupt pending, T0 copies PC to the address register, T1 reads the instruction and increments PC, and T2 loads the address register from instruction bits 11:0 and the indirect bit from bit 15. The operation lines are the one-hot decode of bits 14:12, and at most one phase line is active.
- R3: In T3 a memory-reference instruction (opcode 0 to 6) with bit 15 set reads memory at the address register and loads the address register from the result. With bit 15 clear, T3 changes nothing. In both cases execution continues in T4.
- R4: Opcode 7 with bit 15 clear executes in T3 and returns to T0 (4 cycles). PC advances by one if any selected test holds: bit 4 for accumulator sign clear, bit 3 for sign set, bit 2 for accumulator zero, bit 1 for carry clear.
- R5: Opcode 7 with bit 15 set executes in T3 and returns to T0. Bit 9 skips when the input flag is set and bit 8 skips when the output flag is set. Bit 7 sets interrupt-enable and bit 6 clears it.
- R6: Opcodes 0, 1 and 2 read the operand into the data register in T4 and end after T5 (6 cycles).
- R7: Opcode 3 writes the accumulator input to memory at the address register in T4 and ends (5 cycles); no phase reads and writes at once.
- R8: Opcode 4 loads PC from the address register in T4 and ends (5 cycles).
- R9: Opcode 5 writes PC to memory at the address register and increments the address register in T4, then loads PC from it in T5 (6 cycles).
- R10: Opcode 6 reads in T4, increments the data register in T5, writes it back in T6 and advances PC when the incremented value is zero (7 cycles).
- R11: Interrupt-pending sets only when interrupt-enable is set, a device flag is up and none of T0, T1, T2 is active.
- R12: With interrupt-pending set, T0 clears the address register and copies PC to the temporary register, T1 writes it to address 0 and clears PC, and T2 sets PC to 1, clears interrupt-enable and interrupt-pending, and returns to T0.
- R13: Register-reference bit 0 clears the run flip-flop. Afterwards no phase is active, no strobe rises and PC holds until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rdata | input | 16 | Memory read data, valid in the phase of the read |
| ac_in | input | 16 | Accumulator value from the datapath |
| e_in | input | 1 | Carry bit from the datapath |
| fgi | input | 1 | Input device flag |
| fgo | input | 1 | Output device flag |
| mem_addr | output | 12 | Memory address (address register) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data |
| t_phase | output | 16 | One-hot timing phases |
| d_op | output | 8 | One-hot decoded opcode |
| ind_bit | output | 1 | Latched indirect bit |
| ir_q | output | 16 | Instruction register |
| dr_q | output | 16 | Data register |
| pc_q | output | 12 | Program counter |
| rr_fire | output | 1 | Register-reference execute strobe (T3) |
| io_fire | output | 1 | Input/output execute strobe (T3) |
| irq_cycle | output | 1 | Interrupt-pending flip-flop |
| ien_q | output | 1 | Interrupt-enable flip-flop |
| running | output | 1 | Run/halt flip-flop |

## Verification
The bench uses the default widths: 16-bit data, 12-bit addresses, a 4-bit phase counter and a 3-bit opcode. With these, every opcode and every skip bit of the two opcode-7 groups can be exercised with real instruction words, and the longest path (T6) sits well inside the sixteen phases. A 256-word memory model covers the operand, pointer and vector addresses used. Because it is small, one instruction can be run from reset and its cycle count, final PC and memory effect compared against the requirements. The same build supports a two-instruction program that enables interrupts and takes the hardware call.

// File: rtl/seq_pkg.sv
package seq_pkg;
  // opcode values decoded from instruction bits 14:12
  typedef enum logic [2:0] {
    OP_AND = 3'd0, OP_ADD = 3'd1, OP_LDA = 3'd2, OP_STA = 3'd3,
    OP_BUN = 3'd4, OP_BSA = 3'd5, OP_ISZ = 3'd6, OP_EXT = 3'd7
  } op_e;

  // register-reference selector bits
  localparam int RB_SIGN_CLR = 4;
  localparam int RB_SIGN_SET = 3;
  localparam int RB_AC_ZERO  = 2;
  localparam int RB_E_CLR    = 1;
  localparam int RB_HALT     = 0;
  // input/output selector bits
  localparam int IB_IN_FLAG  = 9;
  localparam int IB_OUT_FLAG = 8;
  localparam int IB_IEN_ON   = 7;
  localparam int IB_IEN_OFF  = 6;
endpackage

// File: rtl/seq_phase_gen.sv
module seq_phase_gen #(
  parameter int SC_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    sc_clr,
  output logic [(1<<SC_W)-1:0]    t
);
  localparam int NPH = 1 << SC_W;

  logic [SC_W-1:0] sc_q;

  always_ff @(posedge clk) begin
    if (rst)          sc_q <= '0;
    else if (!run)    sc_q <= sc_q;
    else if (sc_clr)  sc_q <= '0;
    else              sc_q <= sc_q + SC_W'(1);
  end

  for (genvar k = 0; k < NPH; k++) begin : g_dec
    assign t[k] = run && (sc_q == SC_W'(k));
  end

  // R2
  phase_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(t));
endmodule

// File: rtl/seq_op_decode.sv
module seq_op_decode #(
  parameter int OPC_W = 3
) (
  input  logic [OPC_W-1:0]        opc,
  output logic [(1<<OPC_W)-1:0]   d
);
  localparam int NOP = 1 << OPC_W;

  for (genvar k = 0; k < NOP; k++) begin : g_dec
    assign d[k] = (opc == OPC_W'(k));
  end
endmodule

// File: rtl/seq_irq_ctrl.sv
module seq_irq_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic fetch_win,
  input  logic fgi,
  input  logic fgo,
  input  logic ien_on,
  input  logic ien_off,
  input  logic irq_done,
  output logic ien_q,
  output logic irq_q
);
  logic irq_req;
  assign irq_req = run && !fetch_win && ien_q && (fgi || fgo);

  always_ff @(posedge clk) begin
    if (rst)                       ien_q <= 1'b0;
    else if (irq_done || ien_off)  ien_q <= 1'b0;
    else if (ien_on)               ien_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)           irq_q <= 1'b0;
    else if (irq_done) irq_q <= 1'b0;
    else if (irq_req)  irq_q <= 1'b1;
  end

  // R11
  irq_window_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(ien_q) && !$past(fetch_win) && $past(run));
  // R11
  irq_need_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> ($past(fgi) || $past(fgo)));
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12,
  parameter int SC_W   = 4,
  parameter int OPC_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DATA_W-1:0]        mem_rdata,
  input  logic [DATA_W-1:0]        ac_in,
  input  logic                     e_in,
  input  logic                     fgi,
  input  logic                     fgo,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic                     mem_rd,
  output logic                     mem_wr,
  output logic [DATA_W-1:0]        mem_wdata,
  output logic [(1<<SC_W)-1:0]     t_phase,
  output logic [(1<<OPC_W)-1:0]    d_op,
  output logic                     ind_bit,
  output logic [DATA_W-1:0]        ir_q,
  output logic [DATA_W-1:0]        dr_q,
  output logic [ADDR_W-1:0]        pc_q,
  output logic                     rr_fire,
  output logic                     io_fire,
  output logic                     irq_cycle,
  output logic                     ien_q,
  output logic                     running
);
  import seq_pkg::*;

  localparam int IND_POS = DATA_W - 1;
  localparam int OPC_LSB = IND_POS - OPC_W;
  localparam int NOP     = 1 << OPC_W;
  localparam int PAD_W   = DATA_W - ADDR_W;

  function automatic logic [ADDR_W-1:0] addr_inc(input logic [ADDR_W-1:0] a);
    return a + ADDR_W'(1);
  endfunction

  function automatic logic rr_skip(input logic [DATA_W-1:0] ir,
                                   input logic [DATA_W-1:0] ac, input logic e);
    return (ir[RB_SIGN_CLR] && !ac[DATA_W-1]) || (ir[RB_SIGN_SET] && ac[DATA_W-1]) ||
           (ir[RB_AC_ZERO] && (ac == '0)) || (ir[RB_E_CLR] && !e);
  endfunction

  function automatic logic io_skip(input logic [DATA_W-1:0] ir, input logic fi, input logic fo);
    return (ir[IB_IN_FLAG] && fi) || (ir[IB_OUT_FLAG] && fo);
  endfunction

  logic [(1<<SC_W)-1:0] t;
  logic [NOP-1:0]       d;
  logic [ADDR_W-1:0]    pc_r, ar_r;
  logic [DATA_W-1:0]    ir_r, dr_r, tr_r;
  logic                 ind_r, s_r, irq_r, ien_r;
  logic                 sc_clr;

  // named events
  logic f0, f1, f2, i0, i1, i2, mref, ind_rd, rr_ex, io_ex;
  logic opnd_rd, sta4, bun4, bsa4, bsa5, isz5, isz6, alu5;
  logic halt, skip_any, ien_on, ien_off;

  seq_phase_gen #(.SC_W(SC_W)) u_phase (
    .clk(clk), .rst(rst), .run(s_r), .sc_clr(sc_clr), .t(t)
  );

  seq_op_decode #(.OPC_W(OPC_W)) u_dec (
    .opc(ir_r[OPC_LSB +: OPC_W]), .d(d)
  );

  seq_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .run(s_r), .fetch_win(t[0] | t[1] | t[2]),
    .fgi(fgi), .fgo(fgo), .ien_on(ien_on), .ien_off(ien_off),
    .irq_done(i2), .ien_q(ien_r), .irq_q(irq_r)
  );

  always_comb begin
    f0      = !irq_r && t[0];
    f1      = !irq_r && t[1];
    f2      = !irq_r && t[2];
    i0      = irq_r && t[0];
    i1      = irq_r && t[1];
    i2      = irq_r && t[2];
    mref    = !d[OP_EXT];
    ind_rd  = t[3] && mref && ind_r;
    rr_ex   = t[3] && d[OP_EXT] && !ind_r;
    io_ex   = t[3] && d[OP_EXT] && ind_r;
    opnd_rd = t[4] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]);
    alu5    = t[5] && (d[OP_AND] || d[OP_ADD] || d[OP_LDA]);
    sta4    = t[4] && d[OP_STA];
    bun4    = t[4] && d[OP_BUN];
    bsa4    = t[4] && d[OP_BSA];
    bsa5    = t[5] && d[OP_BSA];
    isz5    = t[5] && d[OP_ISZ];
    isz6    = t[6] && d[OP_ISZ];
    halt    = rr_ex && ir_r[RB_HALT];
    ien_on  = io_ex && ir_r[IB_IEN_ON];
    ien_off = io_ex && ir_r[IB_IEN_OFF];
    skip_any = (rr_ex && rr_skip(ir_r, ac_in, e_in)) ||
               (io_ex && io_skip(ir_r, fgi, fgo)) ||
               (isz6 && (dr_r == '0));
    sc_clr  = rr_ex || io_ex || alu5 || sta4 || bun4 || bsa5 || isz6 || i2;
  end

  always_comb begin
    mem_rd = f1 || ind_rd || opnd_rd;
    mem_wr = sta4 || bsa4 || isz6 || i1;
    if (sta4)      mem_wdata = ac_in;
    else if (bsa4) mem_wdata = {{PAD_W{1'b0}}, pc_r};
    else if (isz6) mem_wdata = dr_r;
    else           mem_wdata = tr_r;
  end

  always_ff @(posedge clk) begin
    if (rst)                  pc_r <= '0;
    else if (i1)              pc_r <= '0;
    else if (bun4 || bsa5)    pc_r <= ar_r;
    else if (f1 || i2 || skip_any) pc_r <= addr_inc(pc_r);
  end

  always_ff @(posedge clk) begin
    if (rst)          ar_r <= '0;
    else if (f0)      ar_r <= pc_r;
    else if (f2)      ar_r <= ir_r[ADDR_W-1:0];
    else if (ind_rd)  ar_r <= mem_rdata[ADDR_W-1:0];
    else if (i0)      ar_r <= '0;
    else if (bsa4)    ar_r <= addr_inc(ar_r);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_r  <= '0;
      ind_r <= 1'b0;
      dr_r  <= '0;
      tr_r  <= '0;
    end else begin
      if (f1)      ir_r  <= mem_rdata;
      if (f2)      ind_r <= ir_r[IND_POS];
      if (opnd_rd) dr_r  <= mem_rdata;
      else if (isz5) dr_r <= dr_r + DATA_W'(1);
      if (i0)      tr_r  <= {{PAD_W{1'b0}}, pc_r};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       s_r <= 1'b1;
    else if (halt) s_r <= 1'b0;
  end

  assign mem_addr  = ar_r;
  assign t_phase   = t;
  assign d_op      = d;
  assign ind_bit   = ind_r;
  assign ir_q      = ir_r;
  assign dr_q      = dr_r;
  assign pc_q      = pc_r;
  assign rr_fire   = rr_ex;
  assign io_fire   = io_ex;
  assign irq_cycle = irq_r;
  assign ien_q     = ien_r;
  assign running   = s_r;

  // R7
  mem_excl_chk: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  // R13
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !running |=> !running && $stable(pc_q) && (t_phase == '0) && !mem_rd && !mem_wr);
  // R12
  irq_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_cycle && t_phase[2]) |=> !irq_cycle && !ien_q && t_phase[0] && (pc_q == ADDR_W'(1)));
  // R8
  bun_target_chk: assert property (@(posedge clk) disable iff (rst)
    (t_phase[4] && d_op[OP_BUN]) |=> (pc_q == $past(mem_addr)) && t_phase[0]);
  // R10
  isz_skip_chk: assert property (@(posedge clk) disable iff (rst)
    (t_phase[6] && d_op[OP_ISZ] && mem_wdata == '0) |=> pc_q == $past(pc_q) + ADDR_W'(1));
endmodule

// File: tb/sim_instr_sequencer.sv
module sim_instr_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ac_in = '0;
  logic        e_in = 1'b0, fgi = 1'b0, fgo = 1'b0;
  logic [15:0] mem_rdata, mem_wdata, ir_q, dr_q, t_phase;
  logic [11:0] mem_addr, pc_q;
  logic [7:0]  d_op;
  logic        mem_rd, mem_wr, ind_bit, rr_fire, io_fire, irq_cycle, ien_q, running;
  logic [15:0] mem [256];

  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  always #2 clk = ~clk;

  instr_sequencer u0 (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .ac_in(ac_in), .e_in(e_in),
    .fgi(fgi), .fgo(fgo), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .t_phase(t_phase), .d_op(d_op), .ind_bit(ind_bit),
    .ir_q(ir_q), .dr_q(dr_q), .pc_q(pc_q), .rr_fire(rr_fire), .io_fire(io_fire),
    .irq_cycle(irq_cycle), .ien_q(ien_q), .running(running)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic start(input logic [15:0] w0, input logic [15:0] opnd);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 256; k++) mem[k] = '0;
    mem[0]      = w0;
    mem[8'h40]  = opnd;
    mem[8'h50]  = 16'h1234;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // run until T0 comes back; returns elapsed cycles
  task automatic to_t0(output int n);
    n = 0;
    do begin
      @(posedge clk); #1;
      n++;
    end while (!t_phase[0] && n < 20);
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
    end
    #1;
  endtask

  typedef struct packed {
    logic [15:0] instr;
    logic [15:0] opnd;
    logic [15:0] ac;
    logic        e;
    logic        fi;
    logic        fo;
    logic [11:0] pc;
    logic [3:0]  cyc;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t TAB [NV] = '{
    '{16'h0040, 16'h00FF, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h001, 4'd6, 4'd6},  // R6 AND
    '{16'h1040, 16'h0003, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h001, 4'd6, 4'd6},  // R6 ADD
    '{16'hA040, 16'h0050, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h001, 4'd6, 4'd3},  // R3 LDA indirect
    '{16'h4040, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h040, 4'd5, 4'd8},  // R8 BUN direct
    '{16'hC040, 16'h0123, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h123, 4'd5, 4'd3},  // R3 BUN indirect
    '{16'h7004, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h002, 4'd4, 4'd4},  // R4 zero test true
    '{16'h7004, 16'h0000, 16'h0001, 1'b0, 1'b0, 1'b0, 12'h001, 4'd4, 4'd4},  // R4 zero test false
    '{16'h7010, 16'h0000, 16'h7FFF, 1'b0, 1'b0, 1'b0, 12'h002, 4'd4, 4'd4},  // R4 sign clear true
    '{16'h7010, 16'h0000, 16'h8000, 1'b0, 1'b0, 1'b0, 12'h001, 4'd4, 4'd4},  // R4 sign clear false
    '{16'h7008, 16'h0000, 16'h8000, 1'b0, 1'b0, 1'b0, 12'h002, 4'd4, 4'd4},  // R4 sign set true
    '{16'h7002, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h002, 4'd4, 4'd4},  // R4 carry clear true
    '{16'h7002, 16'h0000, 16'h0000, 1'b1, 1'b0, 1'b0, 12'h001, 4'd4, 4'd4},  // R4 carry clear false
    '{16'h7014, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h002, 4'd4, 4'd4},  // R4 two true tests, one skip
    '{16'hF200, 16'h0000, 16'h0000, 1'b0, 1'b1, 1'b0, 12'h002, 4'd4, 4'd5},  // R5 input flag skip
    '{16'hF100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h001, 4'd4, 4'd5},  // R5 output flag low
    '{16'hF100, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b1, 12'h002, 4'd4, 4'd5},  // R5 output flag skip
    '{16'h6040, 16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h002, 4'd7, 4'd10}, // R10 wraps to zero
    '{16'h6040, 16'h0005, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h001, 4'd7, 4'd10}, // R10 no skip
    '{16'h5040, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 12'h041, 4'd6, 4'd9},  // R9 call
    '{16'h3040, 16'h0000, 16'hBEEF, 1'b0, 1'b0, 1'b0, 12'h001, 4'd5, 4'd7}   // R7 store
  };

  initial begin
    int n;
    string tag;

    // R1 reset state
    start(16'h7000, 16'h0000);
    chk("R1 phase", 32'(t_phase), 32'h1);
    chk("R1 pc", 32'(pc_q), 32'h0);
    chk("R1 flags", {29'd0, irq_cycle, ien_q, running}, 32'h1);

    // table walk
    for (int v = 0; v < NV; v++) begin
      ac_in = TAB[v].ac; e_in = TAB[v].e; fgi = TAB[v].fi; fgo = TAB[v].fo;
      start(TAB[v].instr, TAB[v].opnd);
      to_t0(n);
      tag = $sformatf("R%0d vec%0d", TAB[v].req, v);
      chk({tag, " cycles"}, 32'(n), 32'(TAB[v].cyc));
      chk({tag, " pc"}, 32'(pc_q), 32'(TAB[v].pc));
      chk({tag, " no irq"}, 32'(irq_cycle), 32'h0); // R11 enable is clear
    end
    ac_in = '0; e_in = 1'b0; fgi = 1'b0; fgo = 1'b0;

    // R2 and R3 decode and indirect read in T3
    start(16'hA040, 16'h0050);
    step(3);
    chk("R2 phase T3", 32'(t_phase), 32'h8);
    chk("R2 op decode", 32'(d_op), 32'h04);
    chk("R2 ind bit", 32'(ind_bit), 32'h1);
    chk("R3 addr", 32'(mem_addr), 32'h040);
    chk("R3 read strobe", 32'(mem_rd), 32'h1);
    to_t0(n);
    chk("R3 operand via pointer", 32'(dr_q), 32'h1234);

    // R6 direct operand
    start(16'h2040, 16'h5A5A);
    to_t0(n);
    chk("R6 operand", 32'(dr_q), 32'h5A5A);

    // R7 store
    ac_in = 16'hBEEF;
    start(16'h3040, 16'h0000);
    to_t0(n);
    chk("R7 stored", 32'(mem[8'h40]), 32'hBEEF);
    ac_in = '0;

    // R9 return address saved
    start(16'h5040, 16'h0000);
    to_t0(n);
    chk("R9 saved pc", 32'(mem[8'h40]), 32'h0001);

    // R10 write back
    start(16'h6040, 16'hFFFF);
    to_t0(n);
    chk("R10 wrap write", 32'(mem[8'h40]), 32'h0000);
    start(16'h6040, 16'h0005);
    to_t0(n);
    chk("R10 incr write", 32'(mem[8'h40]), 32'h0006);

    // R13 halt
    start(16'h7001, 16'h0000);
    step(4);
    chk("R13 stopped", 32'(running), 32'h0);
    chk("R13 no phase", 32'(t_phase), 32'h0);
    step(10);
    chk("R13 pc held", 32'(pc_q), 32'h001);
    chk("R13 no read", 32'(mem_rd), 32'h0);

    // R5, R11, R12 interrupt sequence
    start(16'hF080, 16'h0000);
    mem[1] = 16'h4005;
    to_t0(n);
    chk("R5 enable set", 32'(ien_q), 32'h1);
    chk("R11 idle without flag", 32'(irq_cycle), 32'h0);
    fgi = 1'b1;
    to_t0(n);
    chk("R8 jump cycles", 32'(n), 32'd5);
    chk("R11 pending", 32'(irq_cycle), 32'h1);
    chk("R11 pc at jump", 32'(pc_q), 32'h005);
    step(3);
    chk("R12 back at T0", 32'(t_phase), 32'h1);
    chk("R12 pc vector", 32'(pc_q), 32'h001);
    chk("R12 flags clear", {30'd0, irq_cycle, ien_q}, 32'h0);
    chk("R12 saved return", 32'(mem[0]), 32'h0005);
    fgi = 1'b0;

    // R5 disable
    start(16'hF080, 16'h0000);
    mem[1] = 16'hF040;
    to_t0(n);
    to_t0(n);
    chk("R5 enable cleared", 32'(ien_q), 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule